// File: doc/BRIEF.md
# Sequencer Program RAM Loader

This block gives a host byte-wide access to an instruction store of 512 words of 32 bits each. The host sees four byte registers: a control register, a data window and two address registers. A load-enable bit in the control register opens the store to host access. With the store open, each write to the data window fills one byte of a word, least significant byte first. The fourth byte completes the word, and the word is written into the store in that same clock.

Reads through the data window step through the bytes of the word at the current address in the same order. The address moves to the next word after the fourth byte of a word is written or read. A separate registered fetch port lets the sequencer core read instruction words. A second control bit asks the sequencer to return its program counter to zero.

Top module: `progmem_loader`

## Requirements
- R1: After reset, load enable is 0, the word address is 0, the byte lane is 0, `pc_clr` is 0 and `fetch_data` is 0.
- R2: A host write with `host_sel`=0 (control) sets load enable to `host_wdata` bit 0. Reading the control register returns load enable in bit 0 and zeros in bits 7..1. The `load_en` output follows this bit.
- R3: A control write with `host_wdata` bit 1 set drives `pc_clr` high for exactly the one cycle after the write. The bit is not stored. Any other cycle leaves `pc_clr` low.
- R4: A write with `host_sel`=2 sets address bits 7..0. A write with `host_sel`=3 sets address bit 8 from data bit 0; its other data bits are ignored. Reading `host_sel`=2 returns address bits 7..0, and reading `host_sel`=3 returns address bit 8 in bit 0. Either address write returns the byte lane to 0.
- R5: With load enabled, writes with `host_sel`=1 (data) fill lanes 0, 1 and 2 in turn. The fourth write stores {byte3, byte2, byte1, byte0} at the current address in the cycle of that write.
- R6: The address advances by one only after the fourth byte of a word, and it wraps from 511 to 0.
- R7: With load enabled, `host_rdata` for `host_sel`=1 shows byte [lane] of the word at the current address. Each read strobe on the data window moves to the next lane, and the address advances after lane 3.
- R8: With load disabled, data writes and data reads change neither the store, the address nor the lane. The data window reads as 0.
- R9: When `host_wr` and `host_rd` are both high, only the write takes effect.
- R10: `fetch_data` shows the word at `fetch_addr` one cycle later. If a commit to the same address falls in that cycle, the old word is returned, and the new word appears from the next fetch.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (has side effects on the data window only) |
| host_sel | input | 2 | Register select: 0 control, 1 data, 2 address low, 3 address high |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected register contents (combinational) |
| load_en | output | 1 | Store open for host access |
| pc_clr | output | 1 | One-cycle request to clear the sequencer program counter |
| fetch_addr | input | 9 | Sequencer fetch address |
| fetch_data | output | 32 | Registered instruction word |

## Verification
Two events can fall in the same cycle: a host commit of a fourth byte and a sequencer fetch of the same word. The bench provokes this by staging three bytes, pointing the fetch port at the target address and sending the last byte in that same cycle. It expects the old word on the fetch output first and the new word one cycle later. A second overlap, a write strobe and a read strobe asserted together on the data window, is applied both directed and at random. It is judged by whether the stored word and the lane position match a model in which the write alone acted.

// File: rtl/pml_pkg.sv
package pml_pkg;
    localparam int ADDR_W = 9;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int HI_W   = ADDR_W - BYTE_W;

    localparam int CTRL_LOAD_BIT  = 0;
    localparam int CTRL_PCCLR_BIT = 1;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_DATA    = 2'd1,
        SEL_ADDR_LO = 2'd2,
        SEL_ADDR_HI = 2'd3
    } host_sel_e;
endpackage

// File: rtl/pml_cursor.sv
module pml_cursor
    import pml_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_BYTE_W = BYTE_W,
    parameter int P_LANES  = LANES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_lo,
    input  logic                          ld_hi,
    input  logic                          step,
    input  logic [P_BYTE_W-1:0]           ld_val,
    output logic [P_ADDR_W-1:0]           addr,
    output logic [$clog2(P_LANES)-1:0]    lane
);
    localparam int L_W  = $clog2(P_LANES);
    localparam int H_W  = P_ADDR_W - P_BYTE_W;
    localparam logic [L_W-1:0] LAST = L_W'(P_LANES - 1);

    typedef struct packed {
        logic [P_ADDR_W-1:0] addr;
        logic [L_W-1:0]      lane;
    } cur_t;

    cur_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (ld_lo) begin
            cur_d.addr[P_BYTE_W-1:0] = ld_val;
            cur_d.lane               = '0;
        end else if (ld_hi) begin
            cur_d.addr[P_ADDR_W-1:P_BYTE_W] = ld_val[H_W-1:0];
            cur_d.lane                      = '0;
        end else if (step) begin
            if (cur_q.lane == LAST) begin
                cur_d.lane = '0;
                cur_d.addr = cur_q.addr + 1'b1;
            end else begin
                cur_d.lane = cur_q.lane + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign addr = cur_q.addr;
    assign lane = cur_q.lane;

    // R6: the word address moves by one after the last lane, wrapping
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_lo && !ld_hi && lane == LAST) |=> (addr == $past(addr) + 1'b1 && lane == '0));
    // R6: inside a word the address stays put
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_lo && !ld_hi && lane != LAST) |=> ($stable(addr) && lane == $past(lane) + 1'b1));
    // R4: address register writes restart the lane count
    a_r4_lane_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo || ld_hi) |=> (lane == '0));
    // R8: without a load or step the cursor is frozen
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld_lo && !ld_hi) |=> ($stable(addr) && $stable(lane)));
endmodule

// File: rtl/pml_host.sv
module pml_host
    import pml_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_WORD_W = WORD_W,
    parameter int P_BYTE_W = BYTE_W
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   host_wr,
    input  logic                                   host_rd,
    input  logic [1:0]                             host_sel,
    input  logic [P_BYTE_W-1:0]                    host_wdata,
    input  logic [P_ADDR_W-1:0]                    cur_addr,
    input  logic [$clog2(P_WORD_W/P_BYTE_W)-1:0]   cur_lane,
    input  logic [P_WORD_W-1:0]                    ram_word,
    output logic                                   ld_lo,
    output logic                                   ld_hi,
    output logic                                   step,
    output logic                                   ram_we,
    output logic [P_WORD_W-1:0]                    ram_wdata,
    output logic [P_BYTE_W-1:0]                    host_rdata,
    output logic                                   load_en,
    output logic                                   pc_clr
);
    localparam int N_LN  = P_WORD_W / P_BYTE_W;
    localparam int L_W   = $clog2(N_LN);
    localparam int STG_W = (N_LN - 1) * P_BYTE_W;
    localparam logic [L_W-1:0] LAST = L_W'(N_LN - 1);

    typedef struct packed {
        logic             load;
        logic             pcclr;
        logic [STG_W-1:0] stage;
    } hst_t;

    hst_t st_d, st_q;
    logic wr_ctrl, data_wr, data_rd;
    logic [P_BYTE_W-1:0] lane_byte [N_LN];
    logic [P_BYTE_W-1:0] rd_byte;

    for (genvar g = 0; g < N_LN; g++) begin : g_lane
        assign lane_byte[g] = ram_word[g*P_BYTE_W +: P_BYTE_W];
    end

    assign rd_byte = lane_byte[cur_lane];

    always_comb begin
        wr_ctrl = host_wr && (host_sel == SEL_CTRL);
        data_wr = host_wr && (host_sel == SEL_DATA) && st_q.load;
        data_rd = !host_wr && host_rd && (host_sel == SEL_DATA) && st_q.load;
        ld_lo   = host_wr && (host_sel == SEL_ADDR_LO);
        ld_hi   = host_wr && (host_sel == SEL_ADDR_HI);
        step    = data_wr || data_rd;
        ram_we  = data_wr && (cur_lane == LAST);
        ram_wdata = {host_wdata, st_q.stage};

        st_d       = st_q;
        st_d.pcclr = wr_ctrl && host_wdata[CTRL_PCCLR_BIT];
        if (wr_ctrl) st_d.load = host_wdata[CTRL_LOAD_BIT];
        for (int i = 0; i < N_LN - 1; i++) begin
            if (data_wr && cur_lane == L_W'(i))
                st_d.stage[i*P_BYTE_W +: P_BYTE_W] = host_wdata;
        end

        case (host_sel)
            SEL_CTRL:    host_rdata = P_BYTE_W'(st_q.load);
            SEL_DATA:    host_rdata = st_q.load ? rd_byte : '0;
            SEL_ADDR_LO: host_rdata = cur_addr[P_BYTE_W-1:0];
            default:     host_rdata = P_BYTE_W'(cur_addr[P_ADDR_W-1:P_BYTE_W]);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_en = st_q.load;
    assign pc_clr  = st_q.pcclr;

    // R2: load enable tracks bit 0 of the last control write
    a_r2_load_track: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_CTRL) |=> (load_en == $past(host_wdata[CTRL_LOAD_BIT])));
    // R3: program-counter clear pulses once after the request
    a_r3_pc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_CTRL && host_wdata[CTRL_PCCLR_BIT]) |=> pc_clr);
    // R3: no pulse without a request
    a_r3_pc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_sel == SEL_CTRL) |=> !pc_clr);
    // R8: with the store closed, control of the store is frozen
    a_r8_closed_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !(host_wr && host_sel == SEL_CTRL)) |=> !load_en);
endmodule

// File: rtl/pml_ram.sv
module pml_ram
    import pml_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_WORD_W = WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [P_ADDR_W-1:0] waddr,
    input  logic [P_WORD_W-1:0] wdata,
    input  logic [P_ADDR_W-1:0] raddr,
    output logic [P_WORD_W-1:0] rdata,
    input  logic [P_ADDR_W-1:0] fetch_addr,
    output logic [P_WORD_W-1:0] fetch_data
);
    localparam int DEPTH = 1 << P_ADDR_W;

    logic [P_WORD_W-1:0] mem [DEPTH];
    logic [P_WORD_W-1:0] fetch_d, fetch_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rdata   = mem[raddr];
        fetch_d = mem[fetch_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fetch_q <= '0;
        else        fetch_q <= fetch_d;
    end

    assign fetch_data = fetch_q;
endmodule

// File: rtl/progmem_loader.sv
module progmem_loader
    import pml_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              load_en,
    output logic              pc_clr,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [WORD_W-1:0] fetch_data
);
    logic              ld_lo, ld_hi, step, ram_we;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANE_W-1:0] cur_lane;
    logic [WORD_W-1:0] ram_wdata, ram_word;

    pml_cursor #(.P_ADDR_W(ADDR_W), .P_BYTE_W(BYTE_W), .P_LANES(LANES)) cursor_i (
        .clk(clk), .rst_n(rst_n), .ld_lo(ld_lo), .ld_hi(ld_hi), .step(step),
        .ld_val(host_wdata), .addr(cur_addr), .lane(cur_lane)
    );

    pml_host #(.P_ADDR_W(ADDR_W), .P_WORD_W(WORD_W), .P_BYTE_W(BYTE_W)) host_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .cur_addr(cur_addr),
        .cur_lane(cur_lane), .ram_word(ram_word), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .step(step), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .host_rdata(host_rdata), .load_en(load_en), .pc_clr(pc_clr)
    );

    pml_ram #(.P_ADDR_W(ADDR_W), .P_WORD_W(WORD_W)) ram_i (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(cur_addr), .wdata(ram_wdata),
        .raddr(cur_addr), .rdata(ram_word), .fetch_addr(fetch_addr),
        .fetch_data(fetch_data)
    );
endmodule

// File: tb/progmem_loader_tb_top.sv
module progmem_loader_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_wr, host_rd;
    logic [1:0] host_sel;
    logic [7:0] host_wdata, host_rdata;
    logic       load_en, pc_clr;
    logic [8:0] fetch_addr;
    logic [31:0] fetch_data;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_mem [512];
    bit          m_valid [512];
    logic [8:0]  m_addr;
    logic [1:0]  m_lane;
    bit          m_load;
    logic [23:0] m_stage;

    always #10 clk = ~clk;

    progmem_loader dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .load_en(load_en), .pc_clr(pc_clr), .fetch_addr(fetch_addr),
        .fetch_data(fetch_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [1:0] sel, output bit ok);
        ok = 1'b1;
        case (sel)
            2'd0: return {7'b0, m_load};
            2'd1: begin
                if (!m_load) return 8'h00;
                ok = m_valid[m_addr];
                return m_mem[m_addr][m_lane*8 +: 8];
            end
            2'd2: return m_addr[7:0];
            default: return {7'b0, m_addr[8]};
        endcase
    endfunction

    function automatic void lane_step();
        if (m_lane == 2'd3) begin
            m_lane = 2'd0;
            m_addr = m_addr + 9'd1;
        end else m_lane = m_lane + 2'd1;
    endfunction

    function automatic void model_step(input bit wr, input bit rd, input logic [1:0] sel, input logic [7:0] wd);
        if (wr) begin
            case (sel)
                2'd0: m_load = wd[0];
                2'd1: if (m_load) begin
                    if (m_lane == 2'd3) begin
                        m_mem[m_addr]   = {wd, m_stage};
                        m_valid[m_addr] = 1'b1;
                    end else m_stage[m_lane*8 +: 8] = wd;
                    lane_step();
                end
                2'd2: begin m_addr[7:0] = wd; m_lane = 2'd0; end
                default: begin m_addr[8] = wd[0]; m_lane = 2'd0; end
            endcase
        end else if (rd && sel == 2'd1 && m_load) lane_step();
    endfunction

    task automatic op(input bit wr, input bit rd, input logic [1:0] sel, input logic [7:0] wd);
        bit ok;
        logic [7:0] e;
        string tag;
        host_wr = wr; host_rd = rd; host_sel = sel; host_wdata = wd;
        #1;
        e = exp_rdata(sel, ok);
        tag = (sel == 2'd0) ? "R2" : (sel == 2'd1) ? (m_load ? "R7" : "R8") : "R4";
        if (ok) chk(host_rdata == e, tag, 32'(host_rdata), 32'(e));
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        model_step(wr, rd, sel, wd);
        chk(pc_clr == (wr && sel == 2'd0 && wd[1]), "R3", 32'(pc_clr), 32'(wr && sel == 2'd0 && wd[1]));
        chk(load_en == m_load, "R2", 32'(load_en), 32'(m_load));
    endtask

    task automatic fetch_chk(input logic [8:0] a, input string req);
        fetch_addr = a;
        @(posedge clk);
        @(negedge clk);
        chk(fetch_data == m_mem[a], req, fetch_data, m_mem[a]);
    endtask

    task automatic peek(input logic [1:0] sel, input logic [7:0] e, input string req);
        host_sel = sel;
        #1;
        chk(host_rdata == e, req, 32'(host_rdata), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] old;
        void'($urandom(32'd4711));
        rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_sel = 2'd0;
        host_wdata = 8'h00; fetch_addr = 9'd0;
        m_addr = '0; m_lane = '0; m_load = 1'b0; m_stage = '0;
        for (int i = 0; i < 512; i++) m_valid[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(load_en == 1'b0, "R1", 32'(load_en), 0);
        chk(pc_clr == 1'b0, "R1", 32'(pc_clr), 0);
        chk(fetch_data == 32'd0, "R1", fetch_data, 0);
        for (int s = 0; s < 4; s++) peek(2'(s), 8'h00, "R1");

        // R5/R6: fill the whole store, address wraps back to 0
        op(1, 0, 2'd0, 8'h01);
        op(1, 0, 2'd2, 8'h00);
        op(1, 0, 2'd3, 8'hFE);
        for (int i = 0; i < 2048; i++) op(1, 0, 2'd1, 8'($urandom));
        peek(2'd2, 8'h00, "R6");
        peek(2'd3, 8'h00, "R6");
        for (int a = 0; a < 512; a++) fetch_chk(9'(a), "R5");

        // R3: pc clear request pulses and is not stored
        op(1, 0, 2'd0, 8'h03);
        op(0, 0, 2'd0, 8'h00);
        peek(2'd0, 8'h01, "R3");

        // R9: write and read strobes together, write wins
        op(1, 0, 2'd2, 8'd5);
        op(1, 0, 2'd3, 8'd0);
        op(1, 1, 2'd1, 8'hA1);
        op(1, 1, 2'd1, 8'hB2);
        op(1, 1, 2'd1, 8'hC3);
        op(1, 1, 2'd1, 8'hD4);
        chk(m_mem[5] == 32'hD4C3B2A1, "R9", m_mem[5], 32'hD4C3B2A1);
        fetch_chk(9'd5, "R9");
        peek(2'd2, 8'd6, "R9");

        // R4: address write restarts the lane
        op(1, 0, 2'd2, 8'd7);
        op(1, 0, 2'd1, 8'h11);
        op(1, 0, 2'd1, 8'h22);
        op(1, 0, 2'd2, 8'd7);
        for (int i = 0; i < 4; i++) op(1, 0, 2'd1, 8'(8'h40 + i));
        fetch_chk(9'd7, "R4");
        chk(m_mem[7] == 32'h43424140, "R4", m_mem[7], 32'h43424140);

        // R7: byte reads at the top address wrap to 0
        op(1, 0, 2'd2, 8'hFF);
        op(1, 0, 2'd3, 8'h01);
        for (int i = 0; i < 4; i++) op(0, 1, 2'd1, 8'h00);
        peek(2'd2, 8'h00, "R7");
        peek(2'd3, 8'h00, "R7");

        // R8: store closed, data accesses do nothing
        op(1, 0, 2'd2, 8'd9);
        op(1, 0, 2'd1, 8'h77);
        op(1, 0, 2'd0, 8'h00);
        for (int i = 0; i < 3; i++) op(1, 0, 2'd1, 8'hEE);
        op(0, 1, 2'd1, 8'h00);
        op(0, 1, 2'd1, 8'h00);
        op(1, 0, 2'd0, 8'h01);
        peek(2'd2, 8'd9, "R8");
        old = m_mem[9];
        fetch_chk(9'd9, "R8");
        op(0, 1, 2'd1, 8'h00);

        // R10: commit and fetch of the same word in one cycle
        op(1, 0, 2'd2, 8'd20);
        op(1, 0, 2'd3, 8'd0);
        for (int i = 0; i < 3; i++) op(1, 0, 2'd1, 8'(8'h90 + i));
        old = m_mem[20];
        fetch_addr = 9'd20;
        op(1, 0, 2'd1, 8'h93);
        chk(fetch_data == old, "R10", fetch_data, old);
        @(posedge clk);
        @(negedge clk);
        chk(fetch_data == 32'h93929190, "R10", fetch_data, 32'h93929190);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 7)       op(1, 0, 2'd1, 8'($urandom));
            else if (r < 11) op(0, 1, 2'd1, 8'h00);
            else if (r < 12) op(1, 1, 2'd1, 8'($urandom));
            else if (r < 13) op(1, 0, 2'd2, 8'($urandom));
            else if (r < 14) op(1, 0, 2'd3, 8'($urandom));
            else if (r < 15) op(1, 0, 2'd0, {6'($urandom), 1'($urandom), 1'(($urandom % 8) != 0)});
            else             op(0, 1, 2'($urandom), 8'h00);
        end
        for (int a = 0; a < 512; a++) fetch_chk(9'(a), "R5");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule